// File: doc/BRIEF.md
# Microcoded Single-Bus Load Sequencer

This block is a small microprogrammed processor core. One shared 32-bit bus links the register file, the two ALU operand latches, the instruction register, the memory address register and an external memory. A microcode store and a micro-program counter issue one control word per cycle. Each control word selects which single source drives the bus, which registers load from it, and how the micro-PC moves on.

The microcode covers instruction fetch, opcode dispatch, a no-operation and a double-indirect load that writes `rd <- M[M[R[rs]]]`. The double-indirect load takes three microinstructions. It chains two memory reads through the memory address register, so no register other than `rd` and the program counter is written. Memory is external and answers combinationally from the address register, so a read costs one cycle, the same as a register read. The architectural register writes appear on a registered write-report port.

Top module: `ubus_core`

## Requirements
- R1: While `rst` is high, the micro-PC is set to the first fetch state and the program counter (register 31) and all other registers are set to 0. During reset, `wb_valid` is 0, `mem_we` is 0 and `mem_addr` is 0.
- R2: Fetch takes three cycles. In the first cycle, MA and A load PC. In the second, IR loads `M[MA]`. In the third, PC is written with A+4 and the micro-PC dispatches. Each fetch therefore reports a write of the old PC plus 4 to register 31.
- R3: Dispatch decodes the opcode in IR bits [31:26]. Opcode 6'h3D enters the double-indirect load and opcode 6'h00 enters the no-operation. Any other opcode also enters the no-operation and writes nothing except PC.
- R4: The no-operation is a single microinstruction that jumps back to fetch, so such an instruction occupies 4 cycles from one PC write to the next.
- R5: The double-indirect load writes `M[M[R[rs]]]` to `rd`, with rs in IR bits [25:21] and rd in IR bits [20:16]. Its three microinstructions load MA from `R[rs]`, then load MA from memory, then write `rd` from memory and jump to fetch. The instruction occupies 6 cycles from one PC write to the next. The correct value is produced even when rs equals rd.
- R6: Executing any instruction writes no register except PC and the load's `rd`, and `mem_we` never rises.
- R7: In every cycle, at most one of the register file, the ALU, memory and the immediate unit drives the bus.
- R8: Register 0 reads as zero. A write to it is discarded and is not reported.
- R9: A register write that is not discarded is reported one cycle later on `wb_valid`, `wb_idx` and `wb_data`, with the written value.
- R10: `mem_addr` is the byte address held in MA. Memory data returns in the same cycle and is sampled from `mem_rdata`. Pointers stored in memory are byte addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 32 | Byte address from MA |
| mem_rdata | input | 32 | Memory read data for `mem_addr`, same cycle |
| mem_wdata | output | 32 | Bus value offered for a memory write |
| mem_we | output | 1 | Memory write enable |
| wb_valid | output | 1 | A register write occurred in the previous cycle |
| wb_idx | output | 5 | Index of the reported register |
| wb_data | output | 32 | Value written to the reported register |

## Verification
Four properties are checked on every cycle. There is at most one bus driver in any cycle. The instruction register loads only from memory. Dispatch lands only on the no-operation or the load entry. Each register write is reported on the port one cycle later.

Other behaviour can only be shown by the bench scenarios, which run a program against a reference model:
- the pointer-chain values that reach `rd`, including the case rs equal to rd and a load into register 0;
- that an unknown opcode writes nothing;
- that PC advances by 4;
- that instructions take 4 or 6 cycles.

// File: rtl/ubus_pkg.sv
package ubus_pkg;
  localparam int XLEN   = 32;
  localparam int NREG   = 32;
  localparam int RIDX_W = $clog2(NREG);
  localparam int UA_W   = 3;
  localparam int OP_W   = 6;
  localparam int IMM_W  = 16;

  localparam logic [RIDX_W-1:0] PC_IDX = RIDX_W'(NREG - 1);

  localparam logic [OP_W-1:0] OP_NOP  = 6'h00;
  localparam logic [OP_W-1:0] OP_LWII = 6'h3D;

  localparam logic [UA_W-1:0] UA_FETCH0 = 3'd0;
  localparam logic [UA_W-1:0] UA_FETCH1 = 3'd1;
  localparam logic [UA_W-1:0] UA_FETCH2 = 3'd2;
  localparam logic [UA_W-1:0] UA_NOP0   = 3'd3;
  localparam logic [UA_W-1:0] UA_LWII0  = 3'd4;
  localparam logic [UA_W-1:0] UA_LWII1  = 3'd5;
  localparam logic [UA_W-1:0] UA_LWII2  = 3'd6;

  typedef enum logic [1:0] {RS_PC = 2'd0, RS_SRC = 2'd1, RS_DST = 2'd2} rsel_e;
  typedef enum logic [1:0] {ALU_PASS_A = 2'd0, ALU_PASS_B = 2'd1,
                            ALU_INC4 = 2'd2, ALU_ADD = 2'd3} aluop_e;
  typedef enum logic [1:0] {BR_NEXT = 2'd0, BR_JUMP = 2'd1, BR_DISP = 2'd2} ubr_e;

  typedef struct packed {
    logic            ld_ir;
    rsel_e           reg_sel;
    logic            reg_wen;
    logic            en_reg;
    logic            ld_a;
    logic            ld_b;
    aluop_e          alu_op;
    logic            en_alu;
    logic            ld_ma;
    logic            mem_wen;
    logic            en_mem;
    logic            ext_sign;
    logic            en_imm;
    ubr_e            br;
    logic [UA_W-1:0] target;
  } uword_t;
endpackage

// File: rtl/ubus_urom.sv
module ubus_urom
  import ubus_pkg::*;
(
  input  logic [UA_W-1:0] upc,
  output uword_t          cw
);
  function automatic uword_t blank();
    uword_t w;
    w          = '0;
    w.reg_sel  = RS_PC;
    w.alu_op   = ALU_PASS_A;
    w.br       = BR_NEXT;
    w.target   = UA_FETCH0;
    return w;
  endfunction

  always_comb begin
    cw = blank();
    case (upc)
      UA_FETCH0: begin
        cw.reg_sel = RS_PC;
        cw.en_reg  = 1'b1;
        cw.ld_ma   = 1'b1;
        cw.ld_a    = 1'b1;
      end
      UA_FETCH1: begin
        cw.en_mem  = 1'b1;
        cw.ld_ir   = 1'b1;
      end
      UA_FETCH2: begin
        cw.alu_op  = ALU_INC4;
        cw.en_alu  = 1'b1;
        cw.reg_sel = RS_PC;
        cw.reg_wen = 1'b1;
        cw.br      = BR_DISP;
      end
      UA_NOP0: begin
        cw.br      = BR_JUMP;
        cw.target  = UA_FETCH0;
      end
      UA_LWII0: begin
        cw.reg_sel = RS_SRC;
        cw.en_reg  = 1'b1;
        cw.ld_ma   = 1'b1;
      end
      UA_LWII1: begin
        cw.en_mem  = 1'b1;
        cw.ld_ma   = 1'b1;
      end
      UA_LWII2: begin
        cw.en_mem  = 1'b1;
        cw.reg_sel = RS_DST;
        cw.reg_wen = 1'b1;
        cw.br      = BR_JUMP;
        cw.target  = UA_FETCH0;
      end
      default: begin
        cw.br      = BR_JUMP;
        cw.target  = UA_FETCH0;
      end
    endcase
  end
endmodule

// File: rtl/ubus_useq.sv
module ubus_useq
  import ubus_pkg::*;
#(
  parameter logic [OP_W-1:0] LOAD_OP = OP_LWII
)(
  input  logic            clk,
  input  logic            rst,
  input  ubr_e            br,
  input  logic [UA_W-1:0] target,
  input  logic [OP_W-1:0] opcode,
  output logic [UA_W-1:0] upc
);
  logic [UA_W-1:0] disp_ua;
  logic [UA_W-1:0] upc_nx;

  always_comb begin
    case (opcode)
      LOAD_OP: disp_ua = UA_LWII0;
      OP_NOP:  disp_ua = UA_NOP0;
      default: disp_ua = UA_NOP0;
    endcase
  end

  always_comb begin
    case (br)
      BR_JUMP: upc_nx = target;
      BR_DISP: upc_nx = disp_ua;
      default: upc_nx = upc + 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) upc <= UA_FETCH0;
    else     upc <= upc_nx;
  end

  p_reset_fetch_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (upc == UA_FETCH0));

  p_dispatch_target_r3: assert property (@(posedge clk) disable iff (rst)
    (br == BR_DISP) |=> (upc == UA_NOP0 || upc == UA_LWII0));

  p_jump_return_r4: assert property (@(posedge clk) disable iff (rst)
    (br == BR_JUMP) |=> (upc == $past(target)));
endmodule

// File: rtl/ubus_datapath.sv
module ubus_datapath
  import ubus_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  uword_t            cw,
  input  logic [XLEN-1:0]   mem_rdata,
  output logic [XLEN-1:0]   mem_addr,
  output logic [XLEN-1:0]   mem_wdata,
  output logic              mem_we,
  output logic [OP_W-1:0]   opcode,
  output logic              wb_valid,
  output logic [RIDX_W-1:0] wb_idx,
  output logic [XLEN-1:0]   wb_data
);
  localparam int OP_LSB  = XLEN - OP_W;
  localparam int RS_LSB  = OP_LSB - RIDX_W;
  localparam int RD_LSB  = RS_LSB - RIDX_W;

  logic [XLEN-1:0]   rf [NREG];
  logic [XLEN-1:0]   ir, opa, opb, ma;
  logic [RIDX_W-1:0] ridx;
  logic [XLEN-1:0]   rval, aluv, immv, bus;
  logic              rf_write;

  always_comb begin
    case (cw.reg_sel)
      RS_SRC:  ridx = ir[RS_LSB +: RIDX_W];
      RS_DST:  ridx = ir[RD_LSB +: RIDX_W];
      default: ridx = PC_IDX;
    endcase
  end

  assign rval = (ridx == '0) ? '0 : rf[ridx];

  always_comb begin
    case (cw.alu_op)
      ALU_PASS_B: aluv = opb;
      ALU_INC4:   aluv = opa + XLEN'(4);
      ALU_ADD:    aluv = opa + opb;
      default:    aluv = opa;
    endcase
  end

  assign immv = cw.ext_sign ? {{(XLEN-IMM_W){ir[IMM_W-1]}}, ir[IMM_W-1:0]}
                            : {{(XLEN-IMM_W){1'b0}}, ir[IMM_W-1:0]};

  assign bus = ({XLEN{cw.en_reg}} & rval)
             | ({XLEN{cw.en_alu}} & aluv)
             | ({XLEN{cw.en_mem}} & mem_rdata)
             | ({XLEN{cw.en_imm}} & immv);

  assign rf_write = cw.reg_wen && (ridx != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      ir  <= '0;
      opa <= '0;
      opb <= '0;
      ma  <= '0;
    end else begin
      if (cw.ld_ir) ir  <= bus;
      if (cw.ld_a)  opa <= bus;
      if (cw.ld_b)  opb <= bus;
      if (cw.ld_ma) ma  <= bus;
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_rf
    always_ff @(posedge clk) begin
      if (rst)                                    rf[g] <= '0;
      else if (rf_write && ridx == RIDX_W'(g))    rf[g] <= bus;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wb_valid <= 1'b0;
      wb_idx   <= '0;
      wb_data  <= '0;
    end else begin
      wb_valid <= rf_write;
      wb_idx   <= ridx;
      wb_data  <= bus;
    end
  end

  assign mem_addr  = ma;
  assign mem_wdata = bus;
  assign mem_we    = cw.mem_wen;
  assign opcode    = ir[OP_LSB +: OP_W];

  p_one_driver_r7: assert property (@(posedge clk) disable iff (rst)
    $countones({cw.en_reg, cw.en_alu, cw.en_mem, cw.en_imm}) <= 1);

  p_ir_from_mem_r2: assert property (@(posedge clk) disable iff (rst)
    cw.ld_ir |-> cw.en_mem);

  p_wb_follows_r9: assert property (@(posedge clk) disable iff (rst)
    (cw.reg_wen && ridx != '0) |=> (wb_valid && wb_data == $past(bus)
                                    && wb_idx == $past(ridx)));

  p_no_mem_write_r6: assert property (@(posedge clk) disable iff (rst)
    !mem_we);
endmodule

// File: rtl/ubus_core.sv
module ubus_core
  import ubus_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  output logic [XLEN-1:0]   mem_addr,
  input  logic [XLEN-1:0]   mem_rdata,
  output logic [XLEN-1:0]   mem_wdata,
  output logic              mem_we,
  output logic              wb_valid,
  output logic [RIDX_W-1:0] wb_idx,
  output logic [XLEN-1:0]   wb_data
);
  logic [UA_W-1:0] upc;
  uword_t          cw;
  logic [OP_W-1:0] opcode;

  ubus_urom u_rom (
    .upc (upc),
    .cw  (cw)
  );

  ubus_useq #(.LOAD_OP(OP_LWII)) u_seq (
    .clk    (clk),
    .rst    (rst),
    .br     (cw.br),
    .target (cw.target),
    .opcode (opcode),
    .upc    (upc)
  );

  ubus_datapath u_dp (
    .clk       (clk),
    .rst       (rst),
    .cw        (cw),
    .mem_rdata (mem_rdata),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_we    (mem_we),
    .opcode    (opcode),
    .wb_valid  (wb_valid),
    .wb_idx    (wb_idx),
    .wb_data   (wb_data)
  );

  p_r0_unreported_r8: assert property (@(posedge clk) disable iff (rst)
    wb_valid |-> (wb_idx != '0));
endmodule

// File: tb/test_ubus_core.sv
module test_ubus_core;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 256;
  localparam int NINSTR     = 8;
  localparam int WATCHDOG   = 3000;

  typedef struct packed {
    logic [4:0]  idx;
    logic [31:0] data;
    logic [7:0]  gap;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] mem_addr, mem_rdata, mem_wdata;
  logic        mem_we, wb_valid;
  logic [4:0]  wb_idx;
  logic [31:0] wb_data;

  logic [31:0] mem [DEPTH];
  exp_t        sb_q[$];
  int          checks = 0, errors = 0;
  int          expected_total = 0, popped = 0;
  int          cyc = 0, last_pc_cyc = -1;
  bit          done = 1'b0, hung = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign mem_rdata = mem[mem_addr[9:2]];

  ubus_core i_ubus_core (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .mem_wdata(mem_wdata), .mem_we(mem_we), .wb_valid(wb_valid),
    .wb_idx(wb_idx), .wb_data(wb_data)
  );

  function automatic logic [31:0] enc(input logic [5:0] op, input logic [4:0] rs,
                                      input logic [4:0] rd, input logic [15:0] lo);
    return {op, rs, rd, lo};
  endfunction

  function automatic logic [31:0] rd_word(input logic [31:0] byte_addr);
    return mem[byte_addr[9:2]];
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Driver: loads the program and pushes expected register writes
  task automatic drive_program();
    logic [31:0] r [32];
    logic [31:0] pc, w, v;
    int prev_len;
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
    mem[0]  = enc(6'h3D, 5'd0, 5'd1, 16'h0100); // r1 <- M[M[0]]
    mem[1]  = enc(6'h3D, 5'd1, 5'd2, 16'h0000); // r2 <- M[M[r1]]
    mem[2]  = enc(6'h00, 5'd0, 5'd0, 16'h0000); // NOP
    mem[3]  = enc(6'h2A, 5'd5, 5'd6, 16'h0000); // unknown opcode
    mem[4]  = enc(6'h3D, 5'd2, 5'd0, 16'h0000); // load into r0
    mem[5]  = enc(6'h3D, 5'd3, 5'd3, 16'h0000); // rs == rd
    mem[6]  = enc(6'h3D, 5'd1, 5'd4, 16'h0000);
    mem[7]  = enc(6'h00, 5'd0, 5'd0, 16'h0000);
    mem[64]  = 32'h0000_0200;
    mem[128] = 32'h0000_0180;
    mem[96]  = 32'hCAFE_0001;
    for (int i = 0; i < 32; i++) r[i] = '0;
    pc = '0;
    prev_len = 0;
    for (int k = 0; k < NINSTR; k++) begin
      w  = rd_word(pc);
      pc = pc + 32'd4;
      sb_q.push_back('{idx: 5'd31, data: pc, gap: 8'(prev_len)});
      if (w[31:26] == 6'h3D) begin
        v = rd_word(rd_word(r[w[25:21]]));
        if (w[20:16] != 5'd0) begin
          r[w[20:16]] = v;
          sb_q.push_back('{idx: w[20:16], data: v, gap: 8'd0});
        end
        prev_len = 6;
      end else begin
        prev_len = 4;
      end
    end
    expected_total = sb_q.size();
  endtask

  // Monitor: compares observed register writes against the queue
  always @(negedge clk) begin
    if (!rst && !done && !hung) begin
      cyc++;
      if (mem_we) check(1'b0, "R6 memory write", {31'd0, mem_we}, 32'd0);
      if (wb_valid) begin
        if (sb_q.size() == 0) begin
          check(1'b0, "R6 R8 unexpected write idx", {27'd0, wb_idx}, 32'd0);
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          popped++;
          check(wb_idx == e.idx, "R6 R8 R9 write index", {27'd0, wb_idx}, {27'd0, e.idx});
          if (e.idx == 5'd31)
            check(wb_data == e.data, "R1 R2 PC advance", wb_data, e.data);
          else
            check(wb_data == e.data, "R5 R7 R10 loaded value", wb_data, e.data);
          if (e.idx == 5'd31) begin
            if (e.gap != 0)
              check((cyc - last_pc_cyc) == int'(e.gap), "R3 R4 R5 instruction cycles",
                    32'(cyc - last_pc_cyc), {24'd0, e.gap});
            last_pc_cyc = cyc;
          end
          if (popped == expected_total) done = 1'b1;
        end
      end
    end
  end

  initial begin
    drive_program();
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(wb_valid == 1'b0, "R1 wb_valid in reset", {31'd0, wb_valid}, 32'd0);
    check(mem_we == 1'b0, "R1 mem_we in reset", {31'd0, mem_we}, 32'd0);
    check(mem_addr == 32'd0, "R1 mem_addr in reset", mem_addr, 32'd0);
    rst = 1'b0;
    for (int t = 0; t < WATCHDOG && !done; t++) @(posedge clk);
    if (!done) begin
      hung = 1'b1;
      check(1'b0, "watchdog R2", 32'(popped), 32'(expected_total));
    end
    repeat (8) @(negedge clk);
    check(mem_we == 1'b0, "R6 no memory write at end", {31'd0, mem_we}, 32'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule